// File: doc/BRIEF.md
# Load-Multiple Read Burst Splitter

This block accepts one noncacheable multi-word load request and turns it into one or two read address requests on an AXI read address channel. A request carries the word address of its first word and a word count between 1 and 16. Memory is viewed as 32-byte regions of eight 32-bit words. A load whose words stay inside one region is issued as a single piece. A load that runs past the last word of its region is cut at that boundary. The head piece runs from the start word to the end of the region. The tail piece starts at byte offset zero of the next region and carries every remaining word.

Each piece is sent as an incrementing burst. A piece that starts on an 8-byte boundary and has an even word count uses 64-bit beats. Any other piece uses 32-bit beats. With every address request the block also gives the piece index, the number of words the piece returns and a last-piece flag, so that a later read-data stage can join the two responses. The request input is stalled until the final piece of the current load has been accepted.

Top module: `lm_burst_split`

## Requirements
- R1: While reset is high and in the first cycle after it, `ar_valid` is 0 and `req_ready` is 1.
- R2: A load whose start word k (word address bits [2:0]) plus its count is 8 or less gives exactly one piece. That piece has the start byte address, all the words, piece index 0 and the last flag 1.
- R3: A load with k + count above 8 gives a first piece with the start byte address, 8 − k words, piece index 0 and the last flag 0.
- R4: The second piece of a split load has the first piece's address rounded down to 32 bytes plus 32, with 32-bit wrap. It has count − (8 − k) words, piece index 1 and the last flag 1.
- R5: A piece whose byte address has bit 2 clear and whose word count is even uses burst code 2'b01 (INCR), size code 3'b011 (8 bytes) and length words/2 − 1.
- R6: Any other piece uses burst code 2'b01, size code 3'b010 (4 bytes) and length words − 1.
- R7: While `ar_valid` is high and `ar_ready` is low, every address channel output holds its value. The second piece appears in the cycle right after the first piece is accepted.
- R8: `req_ready` falls in the cycle after a request is taken. It stays low until the last piece is accepted and is high in the next cycle, when `ar_valid` is 0.
- R9: Bits [1:0] of `ar_addr` are always 0.
- R10: The count field `req_cnt_m1` holds count − 1, so 4'h0 means 1 word and 4'hF means 16 words. The word counts of the pieces of one load add up to the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Block can take a request |
| req_word_addr | input | ADDR_W-2 | Word address of the first word |
| req_cnt_m1 | input | CNT_W | Word count minus one |
| ar_valid | output | 1 | Address request valid |
| ar_ready | input | 1 | Address request accepted by the channel |
| ar_addr | output | ADDR_W | Byte address of the piece |
| ar_burst | output | 2 | Burst type |
| ar_size | output | 3 | Beat size code |
| ar_len | output | 8 | Beats minus one |
| ar_piece | output | 1 | Piece index, 0 or 1 |
| ar_words | output | CNT_W+1 | Words this piece returns |
| ar_last | output | 1 | This is the final piece of the load |

## Verification
The bench builds the block with its default parameters: a 32-bit address, eight-word regions and a four-bit count field. At this size every start word in a region can be paired with every count from 1 to 16, so all 128 combinations are swept. The sweep covers single pieces, splits at every boundary position, and tail pieces of up to 15 words in both 32-bit and 64-bit encodings. Each combination runs twice: once at an ordinary base address and once in the top region of the address space, where the tail address wraps to zero. Back-pressure stalls of zero to two cycles, varied per piece, exercise holding and sequencing.

// File: rtl/lm_split_pkg.sv
package lm_split_pkg;

  localparam logic [1:0] BURST_INCR = 2'b01;
  localparam logic [2:0] SIZE_4B    = 3'b010;
  localparam logic [2:0] SIZE_8B    = 3'b011;

  typedef struct packed {
    logic [1:0] burst;
    logic [2:0] size;
    logic [7:0] len;
  } ar_enc_t;

endpackage

// File: rtl/lm_split_calc.sv
module lm_split_calc #(
  parameter int ADDR_W   = 32,
  parameter int RGN_LOG2 = 3,
  parameter int CNT_W    = 4
) (
  input  logic [ADDR_W-3:0] word_addr,
  input  logic [CNT_W-1:0]  cnt_m1,
  output logic [ADDR_W-1:0] p0_addr,
  output logic [CNT_W:0]    p0_words,
  output logic [ADDR_W-1:0] p1_addr,
  output logic [CNT_W:0]    p1_words,
  output logic              two_pieces
);
  localparam int WORDS_W   = CNT_W + 1;
  localparam int RGN_WORDS = 1 << RGN_LOG2;
  localparam int HI_W      = ADDR_W - 2 - RGN_LOG2;
  localparam int LO_W      = RGN_LOG2 + 2;
  localparam int CW        = ((WORDS_W > RGN_LOG2 + 1) ? WORDS_W : RGN_LOG2 + 1) + 1;

  logic [CW-1:0] total;
  logic [CW-1:0] room;
  logic [CW-1:0] rest;

  always_comb begin
    total      = CW'(cnt_m1) + CW'(1);
    room       = CW'(RGN_WORDS) - CW'(word_addr[RGN_LOG2-1:0]);
    two_pieces = total > room;
    rest       = total - room;
    p0_addr    = {word_addr, 2'b00};
    p0_words   = two_pieces ? WORDS_W'(room) : WORDS_W'(total);
    p1_addr    = {word_addr[ADDR_W-3:RGN_LOG2] + HI_W'(1), LO_W'(0)};
    p1_words   = two_pieces ? WORDS_W'(rest) : '0;
  end

endmodule

// File: rtl/lm_burst_enc.sv
module lm_burst_enc #(
  parameter int WORDS_W = 5
) (
  input  logic                     dw_aligned,
  input  logic [WORDS_W-1:0]       words,
  output lm_split_pkg::ar_enc_t    enc
);
  import lm_split_pkg::*;

  logic               wide;
  logic [WORDS_W-1:0] beats;

  always_comb begin
    wide      = dw_aligned && !words[0];
    beats     = wide ? (words >> 1) : words;
    enc.burst = BURST_INCR;
    enc.size  = wide ? SIZE_8B : SIZE_4B;
    enc.len   = 8'(beats - WORDS_W'(1));
  end

endmodule

// File: rtl/lm_ar_seq.sv
module lm_ar_seq #(
  parameter int ADDR_W  = 32,
  parameter int WORDS_W = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [ADDR_W-1:0]     p0_addr,
  input  logic [WORDS_W-1:0]    p0_words,
  input  lm_split_pkg::ar_enc_t p0_enc,
  input  logic [ADDR_W-1:0]     p1_addr,
  input  logic [WORDS_W-1:0]    p1_words,
  input  lm_split_pkg::ar_enc_t p1_enc,
  input  logic                  two_pieces,
  input  logic                  ar_ready,
  output logic                  ar_valid,
  output logic [ADDR_W-1:0]     ar_addr,
  output lm_split_pkg::ar_enc_t ar_enc,
  output logic                  ar_piece,
  output logic [WORDS_W-1:0]    ar_words,
  output logic                  ar_last
);
  import lm_split_pkg::*;

  logic                busy;
  logic                pend;
  logic [ADDR_W-1:0]   hold_addr;
  logic [WORDS_W-1:0]  hold_words;
  ar_enc_t             hold_enc;

  assign req_ready = ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      pend       <= 1'b0;
      ar_valid   <= 1'b0;
      ar_addr    <= '0;
      ar_enc     <= '0;
      ar_piece   <= 1'b0;
      ar_words   <= '0;
      ar_last    <= 1'b0;
      hold_addr  <= '0;
      hold_words <= '0;
      hold_enc   <= '0;
    end else if (!busy) begin
      if (req_valid) begin
        busy       <= 1'b1;
        ar_valid   <= 1'b1;
        ar_addr    <= p0_addr;
        ar_enc     <= p0_enc;
        ar_words   <= p0_words;
        ar_piece   <= 1'b0;
        ar_last    <= ~two_pieces;
        pend       <= two_pieces;
        hold_addr  <= p1_addr;
        hold_words <= p1_words;
        hold_enc   <= p1_enc;
      end
    end else if (ar_valid && ar_ready) begin
      if (pend) begin
        ar_addr  <= hold_addr;
        ar_enc   <= hold_enc;
        ar_words <= hold_words;
        ar_piece <= 1'b1;
        ar_last  <= 1'b1;
        pend     <= 1'b0;
      end else begin
        ar_valid <= 1'b0;
        busy     <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/lm_burst_split.sv
module lm_burst_split #(
  parameter int ADDR_W   = 32,
  parameter int RGN_LOG2 = 3,
  parameter int CNT_W    = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-3:0]   req_word_addr,
  input  logic [CNT_W-1:0]    req_cnt_m1,
  output logic                ar_valid,
  input  logic                ar_ready,
  output logic [ADDR_W-1:0]   ar_addr,
  output logic [1:0]          ar_burst,
  output logic [2:0]          ar_size,
  output logic [7:0]          ar_len,
  output logic                ar_piece,
  output logic [CNT_W:0]      ar_words,
  output logic                ar_last
);
  import lm_split_pkg::*;

  localparam int WORDS_W = CNT_W + 1;
  localparam int NPIECE  = 2;

  logic [ADDR_W-1:0]  p_addr  [NPIECE];
  logic [WORDS_W-1:0] p_words [NPIECE];
  ar_enc_t            p_enc   [NPIECE];
  logic               two_pieces;
  ar_enc_t            ar_enc;

  lm_split_calc #(
    .ADDR_W   (ADDR_W),
    .RGN_LOG2 (RGN_LOG2),
    .CNT_W    (CNT_W)
  ) u_calc (
    .word_addr  (req_word_addr),
    .cnt_m1     (req_cnt_m1),
    .p0_addr    (p_addr[0]),
    .p0_words   (p_words[0]),
    .p1_addr    (p_addr[1]),
    .p1_words   (p_words[1]),
    .two_pieces (two_pieces)
  );

  for (genvar g = 0; g < NPIECE; g++) begin : g_enc
    lm_burst_enc #(.WORDS_W(WORDS_W)) u_enc (
      .dw_aligned (~p_addr[g][2]),
      .words      (p_words[g]),
      .enc        (p_enc[g])
    );
  end

  lm_ar_seq #(
    .ADDR_W  (ADDR_W),
    .WORDS_W (WORDS_W)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .p0_addr    (p_addr[0]),
    .p0_words   (p_words[0]),
    .p0_enc     (p_enc[0]),
    .p1_addr    (p_addr[1]),
    .p1_words   (p_words[1]),
    .p1_enc     (p_enc[1]),
    .two_pieces (two_pieces),
    .ar_ready   (ar_ready),
    .ar_valid   (ar_valid),
    .ar_addr    (ar_addr),
    .ar_enc     (ar_enc),
    .ar_piece   (ar_piece),
    .ar_words   (ar_words),
    .ar_last    (ar_last)
  );

  assign ar_burst = ar_enc.burst;
  assign ar_size  = ar_enc.size;
  assign ar_len   = ar_enc.len;

endmodule

// File: rtl/lm_burst_split_chk.sv
module lm_burst_split_chk #(
  parameter int ADDR_W   = 32,
  parameter int RGN_LOG2 = 3,
  parameter int CNT_W    = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                req_valid,
  input logic                req_ready,
  input logic                ar_valid,
  input logic                ar_ready,
  input logic [ADDR_W-1:0]   ar_addr,
  input logic [1:0]          ar_burst,
  input logic [2:0]          ar_size,
  input logic [7:0]          ar_len,
  input logic                ar_piece,
  input logic [CNT_W:0]      ar_words,
  input logic                ar_last
);
  localparam int RGN_WORDS = 1 << RGN_LOG2;
  localparam int RLSB      = RGN_LOG2 + 2;

  // R7
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (rst)
    ar_valid && !ar_ready |=> ar_valid && $stable(ar_addr) && $stable(ar_len) &&
      $stable(ar_size) && $stable(ar_piece) && $stable(ar_words) && $stable(ar_last));

  // R8
  req_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_ready && ar_valid));

  // R7
  first_piece_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> ar_valid && !ar_piece);

  // R3
  head_in_region_chk: assert property (@(posedge clk) disable iff (rst)
    ar_valid && !ar_piece |-> int'(ar_addr[RLSB-1:2]) + int'(ar_words) <= RGN_WORDS);

  // R4
  tail_at_region_start_chk: assert property (@(posedge clk) disable iff (rst)
    ar_valid && ar_piece |-> ar_addr[RLSB-1:0] == '0 && ar_last);

  // R5
  wide_beats_chk: assert property (@(posedge clk) disable iff (rst)
    ar_valid && ar_size == 3'b011 |-> !ar_addr[2] && (int'(ar_len) + 1) * 2 == int'(ar_words));

  // R6
  narrow_beats_chk: assert property (@(posedge clk) disable iff (rst)
    ar_valid && ar_size == 3'b010 |-> int'(ar_len) + 1 == int'(ar_words));

  // R5
  incr_burst_chk: assert property (@(posedge clk) disable iff (rst)
    ar_valid |-> ar_burst == 2'b01);

  // R9
  word_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    ar_valid |-> ar_addr[1:0] == 2'b00);

endmodule

bind lm_burst_split lm_burst_split_chk #(
  .ADDR_W   (ADDR_W),
  .RGN_LOG2 (RGN_LOG2),
  .CNT_W    (CNT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .ar_valid  (ar_valid),
  .ar_ready  (ar_ready),
  .ar_addr   (ar_addr),
  .ar_burst  (ar_burst),
  .ar_size   (ar_size),
  .ar_len    (ar_len),
  .ar_piece  (ar_piece),
  .ar_words  (ar_words),
  .ar_last   (ar_last)
);

// File: tb/lm_burst_split_bench.sv
module lm_burst_split_bench;
  localparam int ADDR_W   = 32;
  localparam int RGN_LOG2 = 3;
  localparam int CNT_W    = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-3:0] req_word_addr = '0;
  logic [CNT_W-1:0]  req_cnt_m1 = '0;
  logic              ar_valid;
  logic              ar_ready = 1'b0;
  logic [ADDR_W-1:0] ar_addr;
  logic [1:0]        ar_burst;
  logic [2:0]        ar_size;
  logic [7:0]        ar_len;
  logic              ar_piece;
  logic [CNT_W:0]    ar_words;
  logic              ar_last;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  lm_burst_split #(.ADDR_W(ADDR_W), .RGN_LOG2(RGN_LOG2), .CNT_W(CNT_W)) u_lm_burst_split (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_word_addr(req_word_addr), .req_cnt_m1(req_cnt_m1),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr), .ar_burst(ar_burst),
    .ar_size(ar_size), .ar_len(ar_len), .ar_piece(ar_piece), .ar_words(ar_words),
    .ar_last(ar_last)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_piece(input string tag, input logic [31:0] ea, input int ew,
                             input int eidx, input bit elast);
    bit wide;
    wide = (ea[2] == 1'b0) && (ew % 2 == 0);
    chk("R7 valid", 64'(ar_valid), 64'd1);
    chk("R8 ready low", 64'(req_ready), 64'd0);
    chk({tag, " addr"}, 64'(ar_addr), 64'(ea));
    chk({tag, " words"}, 64'(ar_words), 64'(ew));
    chk({tag, " index"}, 64'(ar_piece), 64'(eidx));
    chk({tag, " last"}, 64'(ar_last), 64'(elast));
    chk("R9 low bits", 64'(ar_addr[1:0]), 64'd0);
    if (wide) begin
      chk("R5 burst", 64'(ar_burst), 64'd1);
      chk("R5 size", 64'(ar_size), 64'd3);
      chk("R5 len", 64'(ar_len), 64'(ew / 2 - 1));
    end else begin
      chk("R6 burst", 64'(ar_burst), 64'd1);
      chk("R6 size", 64'(ar_size), 64'd2);
      chk("R6 len", 64'(ar_len), 64'(ew - 1));
    end
  endtask

  // called at a falling edge while the block is idle
  task automatic run_req(input logic [31:0] base, input int k, input int cnt);
    logic [31:0] a0, a1;
    int room, w0, w1, npc, stall;
    bit two;
    a0   = {base[31:5], 5'b0} + 32'(k * 4);
    room = 8 - k;
    two  = (cnt > room);
    w0   = two ? room : cnt;
    w1   = cnt - w0;
    a1   = {a0[31:5], 5'b0} + 32'd32;
    npc  = two ? 2 : 1;
    chk("R10 count sum", 64'(w0 + w1), 64'(cnt));
    req_valid     = 1'b1;
    req_word_addr = a0[31:2];
    req_cnt_m1    = 4'(cnt - 1);
    @(negedge clk);
    req_valid = 1'b0;
    for (int p = 0; p < npc; p++) begin
      string tag;
      tag   = !two ? "R2" : (p == 0 ? "R3" : "R4");
      stall = (k + cnt + p) % 3;
      for (int s = 0; s < stall; s++) begin
        check_piece(tag, p == 0 ? a0 : a1, p == 0 ? w0 : w1, p, p == npc - 1);
        @(negedge clk);
      end
      check_piece(tag, p == 0 ? a0 : a1, p == 0 ? w0 : w1, p, p == npc - 1);
      ar_ready = 1'b1;
      @(negedge clk);
      ar_ready = 1'b0;
    end
    chk("R8 ready back", 64'(req_ready), 64'd1);
    chk("R8 valid drops", 64'(ar_valid), 64'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 valid in reset", 64'(ar_valid), 64'd0);
    chk("R1 ready in reset", 64'(req_ready), 64'd1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 valid after reset", 64'(ar_valid), 64'd0);
    chk("R1 ready after reset", 64'(req_ready), 64'd1);
    for (int b = 0; b < 2; b++) begin
      for (int k = 0; k < 8; k++) begin
        for (int c = 1; c <= 16; c++) begin
          run_req(b == 0 ? 32'h1234_5600 : 32'hFFFF_FFE0, k, c);
        end
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule